// File: doc/BRIEF.md
# Mode-0 Parallel Port Controller

A 24-line programmable parallel I/O peripheral restricted to basic operation: no strobes, no handshakes, only direct reads and writes of port data. The lines form two 8-bit ports (A and B) and a third port C that is split into two independently directed 4-bit halves. A host CPU programs the direction of each of the four groups through a control byte and then reads or writes the ports over an 8-bit data bus.

The host side has an active-low select, active-low read and write strobes, a 2-bit register address and an active-high reset. Writes take effect on the rising edge of the write strobe, which is sampled in the block's clock domain. Reads are combinational: an input group returns the live pin levels, and an output group returns its output latch. Each of the 24 pins has its own data-out and output-enable signal, so the block can drive bidirectional pads. A control write with bit 7 clear sets or clears a single port C bit without a read-modify-write.

Top module: `ppi_mode0`

## Requirements
- R1: While `rst` is high and after it is released, the stored control byte is 9Bh, every output enable is 0 and every output latch is 0.
- R2: `addr` selects the target: 00 is port A, 01 is port B, 10 is port C (upper nibble in bits 7:4, lower in 3:0) and 11 is the control byte.
- R3: In a control byte with bit 7 set, bit 4 gives the direction of port A, bit 1 of port B, bit 3 of the upper half of C and bit 0 of the lower half of C. A value of 1 means input (enables 0) and 0 means output (all enables of that group 1). All 16 combinations are supported.
- R4: A control write with bit 7 set clears all 24 output latches to zero.
- R5: The mode fields, bits 6:5 and bit 2, are stored as zero whatever was written. Reading address 11 returns the stored control byte.
- R6: A control write with bit 7 clear sets or clears the port C bit whose index is given by data bits 3:1, using data bit 0 as the new value. Indices 0 to 3 address the lower half and 4 to 7 the upper half. The write changes nothing when the addressed half is an input, and it leaves the control byte unchanged.
- R7: A write is committed on the first clock edge at which `wr_n` is sampled high after being sampled low, provided `cs_n` is low at that edge. A strobe with `cs_n` high has no effect.
- R8: A read of an input group returns the pin levels present during the read. A read of an output group returns its latch.
- R9: `d_oe` is high only while `cs_n` and `rd_n` are both low. `d_out` is zero while `d_oe` is low.
- R10: A data write to a port updates its latch whatever its direction. The latch value always appears on that port's data-out pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high reset |
| cs_n | input | 1 | Active-low select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Register address |
| d_in | input | 8 | Write data from host |
| d_out | output | 8 | Read data to host |
| d_oe | output | 1 | Read data bus drive enable |
| pa_i | input | 8 | Port A pin levels |
| pa_o | output | 8 | Port A latch |
| pa_oe | output | 8 | Port A output enables |
| pb_i | input | 8 | Port B pin levels |
| pb_o | output | 8 | Port B latch |
| pb_oe | output | 8 | Port B output enables |
| pc_i | input | 8 | Port C pin levels |
| pc_o | output | 8 | Port C latch |
| pc_oe | output | 8 | Port C output enables |

## Verification
Reads are combinational, so `d_out` and `d_oe` are due in the same cycle as the `cs_n`, `rd_n`, `addr` and pin levels that drive them. The bench samples them 1 ns after applying those inputs, away from any edge. Writes land on the clock edge that sees `wr_n` high after a low sample. The latches, enables and control byte change at that edge, so the bench checks them on the following falling edge. The bench sweeps all 16 direction settings with computed pin and latch patterns. It also exercises the single-bit port C writes on both halves in each direction, the deselected strobes and the mode-field masking.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
   typedef enum logic [1:0] {
      SEL_PA   = 2'b00,
      SEL_PB   = 2'b01,
      SEL_PC   = 2'b10,
      SEL_CTRL = 2'b11
   } ppi_sel_e;

   localparam int unsigned NGRP   = 4;
   localparam int unsigned G_PA   = 0;
   localparam int unsigned G_PB   = 1;
   localparam int unsigned G_PCL  = 2;
   localparam int unsigned G_PCU  = 3;

   // bits that survive a mode-set write: flag plus the four direction bits
   localparam logic [7:0] CTRL_KEEP = 8'b1001_1011;

   function automatic logic [7:0] ctrl_clean(input logic [7:0] raw);
      return raw & CTRL_KEEP;
   endfunction

   // direction bit (1 = input) of group g in a stored control byte
   function automatic logic grp_dir(input logic [7:0] c, input int unsigned g);
      case (g)
         G_PA:    return c[4];
         G_PB:    return c[1];
         G_PCL:   return c[0];
         default: return c[3];
      endcase
   endfunction
endpackage

// File: rtl/ppi_strobe.sv
module ppi_strobe (
   input  logic clk,
   input  logic rst,
   input  logic cs_n,
   input  logic wr_n,
   output logic fire
);
   logic wr_q;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) wr_q <= 1'b1;
      else     wr_q <= wr_n;
   end

   assign fire = wr_n & ~wr_q & ~cs_n;

   // R7: a commit needs a low strobe sample on the previous edge
   a_r7_fire_after_low: assert property (@(posedge clk) disable iff (rst)
      fire |-> $past(wr_n) == 1'b0);
endmodule

// File: rtl/ppi_ctrl_reg.sv
module ppi_ctrl_reg #(
   parameter int unsigned   DW        = 8,
   parameter logic [DW-1:0] RESET_VAL = 8'h9B
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] ctrl
);
   import ppi_pkg::*;

   if (DW != 8) begin : g_bad_dw
      $error("ppi_ctrl_reg: control byte must be 8 bits");
   end
   if (RESET_VAL[7] != 1'b1 || (RESET_VAL & ~CTRL_KEEP) != 8'h00) begin : g_bad_rst
      $error("ppi_ctrl_reg: reset value must be a mode-set byte with zero mode fields");
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst)       ctrl <= RESET_VAL;
      else if (load) ctrl <= ctrl_clean(din);
   end

   // R1: reset value holds through a held reset
   a_r1_reset_value: assert property (@(posedge clk)
      (rst && $past(rst)) |-> ctrl == RESET_VAL);
   // R5: mode fields never stored as one
   a_r5_mode_zero: assert property (@(posedge clk) disable iff (rst)
      load |=> (ctrl[6:5] == 2'b00 && ctrl[2] == 1'b0));
   // R6: the control byte holds when no mode-set write occurs
   a_r6_ctrl_hold: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(ctrl));
endmodule

// File: rtl/ppi_group.sv
module ppi_group #(
   parameter int unsigned W  = 8,
   localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          dir_in,
   input  logic          clr,
   input  logic          wr_en,
   input  logic [W-1:0]  wr_data,
   input  logic          bit_en,
   input  logic [IW-1:0] bit_idx,
   input  logic          bit_val,
   input  logic [W-1:0]  pin_i,
   output logic [W-1:0]  latch_o,
   output logic [W-1:0]  oe_o,
   output logic [W-1:0]  rd_o
);
   if (W < 2 || (W & (W - 1)) != 0) begin : g_bad_w
      $error("ppi_group: width must be a power of two of at least 2");
   end

   logic [W-1:0] latch_q;
   logic [W-1:0] latch_d;

   always_comb begin
      latch_d = latch_q;
      if (clr) begin
         latch_d = '0;
      end else if (wr_en) begin
         latch_d = wr_data;
      end else if (bit_en && !dir_in) begin
         latch_d[bit_idx] = bit_val;
      end
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) latch_q <= '0;
      else     latch_q <= latch_d;
   end

   assign latch_o = latch_q;
   assign oe_o    = {W{~dir_in}};
   assign rd_o    = dir_in ? pin_i : latch_q;

   // R4: mode-set clears the latch
   a_r4_clear: assert property (@(posedge clk) disable iff (rst)
      clr |=> latch_o == '0);
   // R10: byte write lands regardless of direction
   a_r10_byte_write: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !clr) |=> latch_o == $past(wr_data));
   // R6: single-bit write on an input half is ignored
   a_r6_bit_ignored: assert property (@(posedge clk) disable iff (rst)
      (bit_en && dir_in && !clr && !wr_en) |=> $stable(latch_o));
   // R6: single-bit write on an output half sets the chosen bit
   a_r6_bit_applied: assert property (@(posedge clk) disable iff (rst)
      (bit_en && !dir_in && !clr && !wr_en) |=> latch_o[$past(bit_idx)] == $past(bit_val));
endmodule

// File: rtl/ppi_mode0.sv
module ppi_mode0 #(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned PORT_W     = 8,
   parameter logic [7:0]  RESET_CTRL = 8'h9B
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] d_in,
   output logic [DATA_W-1:0] d_out,
   output logic              d_oe,
   input  logic [PORT_W-1:0] pa_i,
   output logic [PORT_W-1:0] pa_o,
   output logic [PORT_W-1:0] pa_oe,
   input  logic [PORT_W-1:0] pb_i,
   output logic [PORT_W-1:0] pb_o,
   output logic [PORT_W-1:0] pb_oe,
   input  logic [PORT_W-1:0] pc_i,
   output logic [PORT_W-1:0] pc_o,
   output logic [PORT_W-1:0] pc_oe
);
   import ppi_pkg::*;

   localparam int unsigned NIB_W   = PORT_W / 2;
   localparam int unsigned TOTAL_W = 3 * PORT_W;
   localparam int unsigned CIDX_W  = $clog2(PORT_W);

   if (DATA_W != 8 || PORT_W != DATA_W) begin : g_bad_w
      $error("ppi_mode0: data bus and ports must both be 8 bits");
   end

   // ---------------- write strobe ----------------
   logic fire;
   ppi_strobe u_strobe (
      .clk  (clk),
      .rst  (rst),
      .cs_n (cs_n),
      .wr_n (wr_n),
      .fire (fire)
   );

   ppi_sel_e sel;
   assign sel = ppi_sel_e'(addr);

   logic mode_set, bit_cmd;
   assign mode_set = fire && (sel == SEL_CTRL) &&  d_in[7];
   assign bit_cmd  = fire && (sel == SEL_CTRL) && !d_in[7];

   // ---------------- control byte ----------------
   logic [7:0] ctrl;
   ppi_ctrl_reg #(.DW(8), .RESET_VAL(RESET_CTRL)) u_ctrl (
      .clk  (clk),
      .rst  (rst),
      .load (mode_set),
      .din  (d_in),
      .ctrl (ctrl)
   );

   // ---------------- port groups ----------------
   logic [TOTAL_W-1:0] all_i, all_o, all_oe, all_rd;
   assign all_i = {pc_i, pb_i, pa_i};

   logic [CIDX_W-1:0] cidx;
   assign cidx = d_in[CIDX_W:1];

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      localparam int unsigned GW  = (g < 2) ? PORT_W : NIB_W;
      localparam int unsigned OFF = (g < 2) ? g * PORT_W : 2 * PORT_W + (g - 2) * NIB_W;
      localparam int unsigned GIW = $clog2(GW);

      logic          wen;
      logic [GW-1:0] wdata;
      logic          ben;

      if (g == G_PA) begin : g_a
         assign wen   = fire && (sel == SEL_PA);
         assign wdata = d_in;
         assign ben   = 1'b0;
      end else if (g == G_PB) begin : g_b
         assign wen   = fire && (sel == SEL_PB);
         assign wdata = d_in;
         assign ben   = 1'b0;
      end else if (g == G_PCL) begin : g_cl
         assign wen   = fire && (sel == SEL_PC);
         assign wdata = d_in[NIB_W-1:0];
         assign ben   = bit_cmd && !cidx[CIDX_W-1];
      end else begin : g_cu
         assign wen   = fire && (sel == SEL_PC);
         assign wdata = d_in[PORT_W-1:NIB_W];
         assign ben   = bit_cmd && cidx[CIDX_W-1];
      end

      ppi_group #(.W(GW)) u_grp (
         .clk     (clk),
         .rst     (rst),
         .dir_in  (grp_dir(ctrl, g)),
         .clr     (mode_set),
         .wr_en   (wen),
         .wr_data (wdata),
         .bit_en  (ben),
         .bit_idx (cidx[GIW-1:0]),
         .bit_val (d_in[0]),
         .pin_i   (all_i[OFF +: GW]),
         .latch_o (all_o[OFF +: GW]),
         .oe_o    (all_oe[OFF +: GW]),
         .rd_o    (all_rd[OFF +: GW])
      );
   end

   assign pa_o  = all_o[0 +: PORT_W];
   assign pb_o  = all_o[PORT_W +: PORT_W];
   assign pc_o  = all_o[2*PORT_W +: PORT_W];
   assign pa_oe = all_oe[0 +: PORT_W];
   assign pb_oe = all_oe[PORT_W +: PORT_W];
   assign pc_oe = all_oe[2*PORT_W +: PORT_W];

   // ---------------- read path ----------------
   logic [DATA_W-1:0] rd_mux;
   always_comb begin
      unique case (sel)
         SEL_PA:  rd_mux = all_rd[0 +: PORT_W];
         SEL_PB:  rd_mux = all_rd[PORT_W +: PORT_W];
         SEL_PC:  rd_mux = all_rd[2*PORT_W +: PORT_W];
         default: rd_mux = ctrl;
      endcase
   end

   assign d_oe  = ~cs_n & ~rd_n;
   assign d_out = d_oe ? rd_mux : '0;

   // R9: the bus is never driven while deselected
   a_r9_no_drive_deselected: assert property (@(posedge clk) disable iff (rst)
      cs_n |-> (d_out == '0));
   // R7: a deselected strobe leaves all latches and the control byte alone
   a_r7_deselect_ignored: assert property (@(posedge clk) disable iff (rst)
      (cs_n && !fire) |=> ($stable(all_o) && $stable(ctrl)));
   // R1: held reset gives all groups as inputs
   a_r1_reset_inputs: assert property (@(posedge clk)
      (rst && $past(rst)) |-> (all_oe == '0 && all_o == '0));
endmodule

// File: tb/ppi_mode0_test.sv
module ppi_mode0_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic [1:0] addr = 2'b00;
   logic [7:0] d_in = 8'h00;
   logic [7:0] d_out;
   logic       d_oe;
   logic [7:0] pa_i = 8'h00, pb_i = 8'h00, pc_i = 8'h00;
   logic [7:0] pa_o, pa_oe, pb_o, pb_oe, pc_o, pc_oe;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   ppi_mode0 uut (
      .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .addr(addr), .d_in(d_in), .d_out(d_out), .d_oe(d_oe),
      .pa_i(pa_i), .pa_o(pa_o), .pa_oe(pa_oe),
      .pb_i(pb_i), .pb_o(pb_o), .pb_oe(pb_oe),
      .pc_i(pc_i), .pc_o(pc_o), .pc_oe(pc_oe)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // full write cycle; state is due at the edge that sees wr_n high
   task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic sel_n = 1'b0);
      @(negedge clk);
      cs_n = sel_n; addr = a; d_in = d; wr_n = 1'b0;
      @(negedge clk);
      wr_n = 1'b1;
      @(negedge clk);
      cs_n = 1'b1;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] v);
      @(negedge clk);
      cs_n = 1'b0; rd_n = 1'b0; addr = a;
      #1 v = d_out;
      chk("R9 oe during read", {31'b0, d_oe}, 32'd1);
      #1 cs_n = 1'b1; rd_n = 1'b1;
   endtask

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      chk("R1 ctrl oe A", {24'b0, pa_oe}, 32'h0);
      chk("R1 oe C", {24'b0, pc_oe}, 32'h0);
      chk("R1 latch B", {24'b0, pb_o}, 32'h0);
      rst = 1'b0;
      rd(2'b11, v);
      chk("R1 R5 ctrl after reset", {24'b0, v}, 32'h9B);

      // R3 R4 R8 R10 R2: sweep of every direction setting
      for (int c = 0; c < 16; c++) begin
         logic ai, cu, bi, cl;
         logic [7:0] cb, la, lb, lc, pa, pb, pc, ec;
         ai = c[3]; cu = c[2]; bi = c[1]; cl = c[0];
         cb = {3'b100, ai, cu, 1'b0, bi, cl};
         wr(2'b00, 8'hFF); wr(2'b01, 8'hFF); wr(2'b10, 8'hFF);
         wr(2'b11, cb);
         chk("R4 clear A", {24'b0, pa_o}, 32'h0);
         chk("R4 clear C", {24'b0, pc_o}, 32'h0);
         chk("R3 oe A", {24'b0, pa_oe}, ai ? 32'h0 : 32'hFF);
         chk("R3 oe B", {24'b0, pb_oe}, bi ? 32'h0 : 32'hFF);
         chk("R3 oe C", {24'b0, pc_oe}, {24'b0, {4{~cu}}, {4{~cl}}});
         rd(2'b11, v);
         chk("R5 ctrl readback", {24'b0, v}, {24'b0, cb});
         la = 8'(c * 17 + 3); lb = 8'(c * 29 + 5); lc = 8'(c * 53 + 11);
         wr(2'b00, la); wr(2'b01, lb); wr(2'b10, lc);
         chk("R10 latch A", {24'b0, pa_o}, {24'b0, la});
         chk("R10 latch B", {24'b0, pb_o}, {24'b0, lb});
         chk("R10 latch C", {24'b0, pc_o}, {24'b0, lc});
         pa = ~la; pb = 8'(lb ^ 8'h5A); pc = 8'(lc + 8'h77);
         @(negedge clk); pa_i = pa; pb_i = pb; pc_i = pc;
         rd(2'b00, v); chk("R8 R2 read A", {24'b0, v}, {24'b0, ai ? pa : la});
         rd(2'b01, v); chk("R8 R2 read B", {24'b0, v}, {24'b0, bi ? pb : lb});
         ec = {cu ? pc[7:4] : lc[7:4], cl ? pc[3:0] : lc[3:0]};
         rd(2'b10, v); chk("R8 R2 read C", {24'b0, v}, {24'b0, ec});
         // live sampling: change pins, read again with no write between
         @(negedge clk); pa_i = ~pa;
         rd(2'b00, v); chk("R8 live A", {24'b0, v}, {24'b0, ai ? ~pa : la});
      end

      // R6: single-bit port C writes, both halves output
      wr(2'b11, 8'h80);
      wr(2'b11, 8'b0000_1011);            // index 5, value 1
      chk("R6 set bit5", {24'b0, pc_o}, 32'h20);
      wr(2'b11, 8'b0000_0001);            // index 0, value 1
      chk("R6 set bit0", {24'b0, pc_o}, 32'h21);
      wr(2'b11, 8'b0000_1010);            // index 5, value 0
      chk("R6 clear bit5", {24'b0, pc_o}, 32'h01);
      rd(2'b11, v);
      chk("R6 ctrl unchanged", {24'b0, v}, 32'h80);
      // lower half input: index 1 ignored, index 6 applied
      wr(2'b11, 8'h81);
      wr(2'b11, 8'b0000_0011);
      chk("R6 ignored on input half", {24'b0, pc_o}, 32'h00);
      wr(2'b11, 8'b0000_1101);
      chk("R6 upper half applied", {24'b0, pc_o}, 32'h40);
      // upper half input: index 7 ignored
      wr(2'b11, 8'h88);
      wr(2'b11, 8'b0000_1111);
      chk("R6 ignored upper input", {24'b0, pc_o}, 32'h00);

      // R7: strobes while deselected
      wr(2'b11, 8'h80);
      wr(2'b00, 8'hA5);
      wr(2'b00, 8'h3C, 1'b1);
      chk("R7 deselected write ignored", {24'b0, pa_o}, 32'hA5);
      wr(2'b11, 8'h9B, 1'b1);
      chk("R7 deselected control ignored", {24'b0, pa_oe}, 32'hFF);
      // R7: commit edge is the one after wr_n rises, not the falling one
      @(negedge clk);
      cs_n = 1'b0; addr = 2'b01; d_in = 8'h66; wr_n = 1'b0;
      @(negedge clk);
      chk("R7 no commit while low", {24'b0, pb_o}, 32'h00);
      wr_n = 1'b1;
      @(negedge clk);
      chk("R7 commit after rise", {24'b0, pb_o}, 32'h66);
      cs_n = 1'b1;

      // R5: mode fields masked
      wr(2'b11, 8'hFF);
      rd(2'b11, v);
      chk("R5 mode fields zero", {24'b0, v}, 32'h9B);

      // R9: no drive when deselected or not reading
      @(negedge clk);
      cs_n = 1'b1; rd_n = 1'b0; addr = 2'b11;
      #1 chk("R9 oe deselected", {31'b0, d_oe}, 32'd0);
      chk("R9 data zero", {24'b0, d_out}, 32'h0);
      cs_n = 1'b0; rd_n = 1'b1;
      #1 chk("R9 oe no read", {31'b0, d_oe}, 32'd0);
      cs_n = 1'b1;

      // R1: reset mid-run
      wr(2'b11, 8'h80);
      wr(2'b00, 8'h12);
      @(negedge clk); rst = 1'b1;
      @(negedge clk);
      chk("R1 reset latch", {24'b0, pa_o}, 32'h0);
      chk("R1 reset oe", {24'b0, pa_oe}, 32'h0);
      rst = 1'b0;
      rd(2'b11, v);
      chk("R1 reset ctrl", {24'b0, v}, 32'h9B);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule